// File: doc/BRIEF.md
# Zigzag Check-Node Functional Unit

This block is the check-mode datapath of one shared processing unit in an array of units that decode IRA-structured LDPC codes. Each unit owns a run of `Q` consecutive check nodes. It visits them one after another. For every check it also updates the parity node that sits between this check and the next one on the zigzag staircase. That parity node is a plain pass-through, so the message running forward along the staircase never leaves the unit. It lives in a local register called the chain register. Only the message running backward, from a check to the parity node below it, goes to external memory.

For each check the controller gives a start strobe with the check degree, the parity channel LLR, and the backward message that was stored for the next check. The information-node messages then arrive one per valid cycle. The unit replies with one check-to-information message per input, in input order. It then presents the new backward message and the parity a-posteriori LLR, and finally updates the chain register. The chain register is passed to the neighbouring unit through `chainOut`/`chainIn`. It is reloaded at the first check of each run of `Q`. The first unit of the array reloads from the largest LLR instead. Boxplus is done as min-sum: the sign is the product of the signs and the magnitude is the smallest magnitude.

Top module: `zigzag_check_unit`

## Requirements
- R1: After reset `idle` is 1, `outVld` and `doneVld` are 0, and `chainOut` equals +MAX, where MAX = 2^(W-1)-1.
- R2: The k-th `outMsg` of a check equals the min-sum boxplus of three terms: all information inputs except the k-th, the parity message P, and the chain register C. Here P is the saturated sum of the parity LLR and the backward message of the next check.
- R3: `bwdMsg` equals the boxplus of all information inputs with P.
- R4: `appMsg` equals F plus the backward message of the next check, saturated. F is the saturated sum of (boxplus of all inputs with C) and the parity LLR.
- R5: After each check, `chainOut` holds F. The chain register changes at no other time except the group reload of R6.
- R6: At every check whose index within the run of `Q` is 0, C is first loaded from `chainIn`. When `FIRST_UNIT` is 1, C is loaded from +MAX instead.
- R7: When `lastCheck` is 1 at the start, the backward message of the next check is taken as 0 in R2 to R4, whatever `bwdNext` carries.
- R8: Ordering: `outVld` is high for exactly `deg` cycles, starting the cycle after the last accepted input. `doneVld` is then high for one cycle. `idle` returns the cycle after that.
- R9: Every sum saturates to the range [-MAX, +MAX]. An input code of -2^(W-1) is treated as -MAX. No output ever carries -2^(W-1).
- R10: Cycles with `inVld` low are skipped while inputs are collected. A `chkStart` while not idle is ignored. Degree, parity LLR, `bwdNext`, `lastCheck` and `chainIn` are sampled only with an accepted start.
- R11: For a check of degree 1, the single `outMsg` equals the boxplus of P and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| chkStart | input | 1 | start of a check, accepted when idle |
| chkDeg | input | DEG_W | number of information inputs of the check |
| lastCheck | input | 1 | check is the last of the code |
| parLlr | input | W | parity-node channel LLR |
| bwdNext | input | W | stored backward message of the next check |
| inVld | input | 1 | information input valid |
| inMsg | input | W | information-to-check message |
| chainIn | input | W | chain register of the previous unit |
| idle | output | 1 | ready for a start |
| outVld | output | 1 | check-to-information message valid |
| outMsg | output | W | check-to-information message |
| doneVld | output | 1 | backward message and parity LLR valid |
| bwdMsg | output | W | backward message to be stored for this check |
| appMsg | output | W | parity a-posteriori LLR |
| chainOut | output | W | chain register to the next unit |

## Verification
The bench sweeps every input code through one position of a degree-2 check. It then runs a long mixed sequence of degrees 1 to 4 with stalls, spurious starts and last-of-code checks, against an arithmetic min-sum model. The sharp corners are these:
- Equal smallest magnitudes: a design that drops the second minimum returns the wrong extrinsic magnitude.
- Degree 1: a design that forgets the neutral element emits a stale minimum.
- The most negative input code: if it is not clamped, a sign or magnitude comes out wrong.
- The last check: a design that ignores the flag leaks `bwdNext` into P and into the a-posteriori LLR.
- Group reloads every `Q` checks: a design that reloads at the wrong time carries a stale chain value into `chainOut` and into every output after it.

A second instance configured as the first unit confirms that it reloads from +MAX.

// File: rtl/zz_pkg.sv
package zz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_EMIT,
    ST_FIN
  } zzState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startChk;  // accepted start: latch per-check operands
    logic seedMem;   // reload chain register (first check of a run)
    logic takeIn;    // absorb one information message
    logic emitOut;   // present one check-to-information message
    logic finish;    // present backward/app results, update chain register
  } zzStrobe_t;

endpackage

// File: rtl/zz_ctrl.sv
module zz_ctrl
  import zz_pkg::*;
#(
  parameter int MAX_DEG = 8,
  parameter int Q       = 4,
  parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chkStart,
  input  logic [DEG_W-1:0] chkDeg,
  input  logic             inVld,
  output zzStrobe_t        strb,
  output logic [DEG_W-1:0] slot,
  output logic             idle
);

  localparam int GRP_W = (Q > 1) ? $clog2(Q) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(Q - 1);
  localparam logic [DEG_W-1:0] DEG_MAX  = DEG_W'(MAX_DEG);

  zzState_e         state;
  logic [DEG_W-1:0] cnt;
  logic [DEG_W-1:0] degR;
  logic [DEG_W-1:0] effDeg;
  logic [GRP_W-1:0] grp;
  logic             atLast;

  always_comb begin
    if (chkDeg == '0)          effDeg = DEG_W'(1);
    else if (chkDeg > DEG_MAX) effDeg = DEG_MAX;
    else                       effDeg = chkDeg;
  end

  assign atLast = (cnt == degR - DEG_W'(1));
  assign idle   = (state == ST_IDLE);
  assign slot   = cnt;

  always_comb begin
    strb          = '0;
    strb.startChk = idle && chkStart;
    strb.seedMem  = idle && chkStart && (grp == '0);
    strb.takeIn   = (state == ST_LOAD) && inVld;
    strb.emitOut  = (state == ST_EMIT);
    strb.finish   = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      degR  <= DEG_W'(1);
      grp   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (chkStart) begin
          degR  <= effDeg;
          cnt   <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: if (inVld) begin
          if (atLast) begin
            cnt   <= '0;
            state <= ST_EMIT;
          end else begin
            cnt <= cnt + DEG_W'(1);
          end
        end
        ST_EMIT: begin
          if (atLast) begin
            cnt   <= '0;
            state <= ST_FIN;
          end else begin
            cnt <= cnt + DEG_W'(1);
          end
        end
        ST_FIN: begin
          grp   <= (grp == GRP_LAST) ? '0 : grp + GRP_W'(1);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  fin_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> idle);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && chkStart && !strb.finish) |=> ($stable(degR) && !idle));

  // R8
  emit_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeIn && atLast) |=> strb.emitOut);

endmodule

// File: rtl/zz_dpath.sv
module zz_dpath
  import zz_pkg::*;
#(
  parameter int W          = 6,
  parameter int MAX_DEG    = 8,
  parameter int DEG_W      = $clog2(MAX_DEG + 1),
  parameter bit FIRST_UNIT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  zzStrobe_t        strb,
  input  logic [DEG_W-1:0] slot,
  input  logic             lastCheck,
  input  logic [W-1:0]     parLlr,
  input  logic [W-1:0]     bwdNext,
  input  logic [W-1:0]     inMsg,
  input  logic [W-1:0]     chainIn,
  output logic [W-1:0]     outMsg,
  output logic [W-1:0]     bwdMsg,
  output logic [W-1:0]     appMsg,
  output logic [W-1:0]     chainOut
);

  localparam int M_W = W - 1;
  localparam logic [M_W-1:0] MAG_MAX  = {M_W{1'b1}};
  localparam logic [W-1:0]   POS_MAX  = {1'b0, {M_W{1'b1}}};
  localparam logic [W-1:0]   NEG_MAX  = {1'b1, {(W-2){1'b0}}, 1'b1};
  localparam logic [W-1:0]   NEG_CODE = {1'b1, {M_W{1'b0}}};
  localparam logic signed [W:0] SUM_HI = {2'b00, {M_W{1'b1}}};
  localparam logic signed [W:0] SUM_LO = {2'b11, {(W-2){1'b0}}, 1'b1};

  function automatic logic [W-1:0] clampIn(input logic [W-1:0] x);
    return (x == NEG_CODE) ? NEG_MAX : x;
  endfunction

  function automatic logic [M_W-1:0] magOf(input logic [W-1:0] x);
    logic [W-1:0] n;
    n = ~x + W'(1);
    return x[W-1] ? n[M_W-1:0] : x[M_W-1:0];
  endfunction

  function automatic logic [M_W-1:0] minOf(input logic [M_W-1:0] a, input logic [M_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] toMsg(input logic s, input logic [M_W-1:0] m);
    logic [W-1:0] v;
    v = {1'b0, m};
    return s ? (~v + W'(1)) : v;
  endfunction

  function automatic logic [W-1:0] satAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] s;
    s = $signed({a[W-1], a}) + $signed({b[W-1], b});
    if (s > SUM_HI)      return POS_MAX;
    else if (s < SUM_LO) return NEG_MAX;
    else                 return s[W-1:0];
  endfunction

  // per-check state
  logic [W-1:0]       memR;      // forward chain message
  logic [W-1:0]       parR;      // parity channel LLR
  logic [W-1:0]       bwdR;      // backward message of next check (0 at code end)
  logic [M_W-1:0]     min1, min2;
  logic [DEG_W-1:0]   minIdx;
  logic               sgnAcc;
  logic [MAX_DEG-1:0] signBuf;
  logic [MAX_DEG-1:0] signNext;

  logic [W-1:0]       seedVal;
  logic [W-1:0]       inC;
  logic [M_W-1:0]     inMag;

  generate
    if (FIRST_UNIT) begin : g_seedMax
      assign seedVal = POS_MAX;
    end else begin : g_seedChain
      assign seedVal = clampIn(chainIn);
    end
  endgenerate

  assign inC   = clampIn(inMsg);
  assign inMag = magOf(inC);

  always_comb begin
    signNext = signBuf;
    if (strb.takeIn) begin
      for (int g = 0; g < MAX_DEG; g++) begin
        if (DEG_W'(g) == slot) signNext[g] = inC[W-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memR    <= POS_MAX;
      parR    <= '0;
      bwdR    <= '0;
      min1    <= MAG_MAX;
      min2    <= MAG_MAX;
      minIdx  <= '0;
      sgnAcc  <= 1'b0;
      signBuf <= '0;
    end else begin
      signBuf <= signNext;
      if (strb.startChk) begin
        parR   <= clampIn(parLlr);
        bwdR   <= lastCheck ? '0 : clampIn(bwdNext);
        min1   <= MAG_MAX;
        min2   <= MAG_MAX;
        minIdx <= '0;
        sgnAcc <= 1'b0;
        if (strb.seedMem) memR <= seedVal;
      end
      if (strb.takeIn) begin
        sgnAcc <= sgnAcc ^ inC[W-1];
        if (inMag < min1) begin
          min2   <= min1;
          min1   <= inMag;
          minIdx <= slot;
        end else if (inMag < min2) begin
          min2 <= inMag;
        end
      end
      if (strb.finish) memR <= fwdMsg;
    end
  end

  // parity-to-check message formed from latched operands
  logic [W-1:0]       pqMsg;
  logic [M_W-1:0]     pqMag, memMag, extraMag;
  logic               extraSgn;
  logic [MAX_DEG-1:0] signSh;
  logic               lrSgn;
  logic [M_W-1:0]     lrMag;
  logic [W-1:0]       fwdBox;
  logic [W-1:0]       fwdMsg;

  assign pqMsg    = satAdd(parR, bwdR);
  assign pqMag    = magOf(pqMsg);
  assign memMag   = magOf(memR);
  assign extraSgn = pqMsg[W-1] ^ memR[W-1];
  assign extraMag = minOf(pqMag, memMag);

  assign signSh = signBuf >> slot;
  assign lrSgn  = sgnAcc ^ signSh[0] ^ extraSgn;
  assign lrMag  = minOf((slot == minIdx) ? min2 : min1, extraMag);
  assign outMsg = toMsg(lrSgn, lrMag);

  assign bwdMsg = toMsg(sgnAcc ^ pqMsg[W-1], minOf(min1, pqMag));

  assign fwdBox   = toMsg(sgnAcc ^ memR[W-1], minOf(min1, memMag));
  assign fwdMsg   = satAdd(fwdBox, parR);
  assign appMsg   = satAdd(fwdMsg, bwdR);
  assign chainOut = memR;

  // R2
  out_mag_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitOut |-> (magOf(outMsg) <= memMag && magOf(outMsg) <= pqMag));

  // R3
  bwd_mag_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (magOf(bwdMsg) <= pqMag && magOf(bwdMsg) <= min1));

  // R9
  no_neg_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitOut || strb.finish) |-> (outMsg != NEG_CODE && appMsg != NEG_CODE
                                       && bwdMsg != NEG_CODE));

  // R5
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.seedMem && !strb.finish) |=> $stable(chainOut));

endmodule

// File: rtl/zigzag_check_unit.sv
module zigzag_check_unit
  import zz_pkg::*;
#(
  parameter int W          = 6,
  parameter int MAX_DEG    = 8,
  parameter int Q          = 4,
  parameter bit FIRST_UNIT = 1'b0,
  parameter int DEG_W      = $clog2(MAX_DEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chkStart,
  input  logic [DEG_W-1:0] chkDeg,
  input  logic             lastCheck,
  input  logic [W-1:0]     parLlr,
  input  logic [W-1:0]     bwdNext,
  input  logic             inVld,
  input  logic [W-1:0]     inMsg,
  input  logic [W-1:0]     chainIn,
  output logic             idle,
  output logic             outVld,
  output logic [W-1:0]     outMsg,
  output logic             doneVld,
  output logic [W-1:0]     bwdMsg,
  output logic [W-1:0]     appMsg,
  output logic [W-1:0]     chainOut
);

  zzStrobe_t        strb;
  logic [DEG_W-1:0] slot;

  zz_ctrl #(.MAX_DEG(MAX_DEG), .Q(Q), .DEG_W(DEG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chkStart(chkStart), .chkDeg(chkDeg),
    .inVld(inVld), .strb(strb), .slot(slot), .idle(idle)
  );

  zz_dpath #(.W(W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W), .FIRST_UNIT(FIRST_UNIT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .slot(slot), .lastCheck(lastCheck),
    .parLlr(parLlr), .bwdNext(bwdNext), .inMsg(inMsg), .chainIn(chainIn),
    .outMsg(outMsg), .bwdMsg(bwdMsg), .appMsg(appMsg), .chainOut(chainOut)
  );

  assign outVld  = strb.emitOut;
  assign doneVld = strb.finish;

endmodule

// File: tb/zigzag_check_unit_tb.sv
module zigzag_check_unit_tb;

  localparam int W      = 6;
  localparam int MAXD   = 4;
  localparam int Q      = 3;
  localparam int DEG_W  = $clog2(MAXD + 1);
  localparam int PMAX   = (1 << (W - 1)) - 1;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rstN;
  logic chkStart, lastCheck, inVld;
  logic [DEG_W-1:0] chkDeg;
  logic [W-1:0] parLlr, bwdNext, inMsg, chainIn;
  logic idle, outVld, doneVld;
  logic [W-1:0] outMsg, bwdMsg, appMsg, chainOut;
  logic idle0, outVld0, doneVld0;
  logic [W-1:0] outMsg0, bwdMsg0, appMsg0, chainOut0;

  always #(CLK_NS / 2) clk = ~clk;

  zigzag_check_unit #(.W(W), .MAX_DEG(MAXD), .Q(Q), .FIRST_UNIT(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .chkStart(chkStart), .chkDeg(chkDeg), .lastCheck(lastCheck),
    .parLlr(parLlr), .bwdNext(bwdNext), .inVld(inVld), .inMsg(inMsg), .chainIn(chainIn),
    .idle(idle), .outVld(outVld), .outMsg(outMsg), .doneVld(doneVld), .bwdMsg(bwdMsg),
    .appMsg(appMsg), .chainOut(chainOut)
  );

  zigzag_check_unit #(.W(W), .MAX_DEG(MAXD), .Q(Q), .FIRST_UNIT(1'b1)) u_dut0 (
    .clk(clk), .rstN(rstN), .chkStart(chkStart), .chkDeg(chkDeg), .lastCheck(lastCheck),
    .parLlr(parLlr), .bwdNext(bwdNext), .inVld(inVld), .inMsg(inMsg), .chainIn(chainIn),
    .idle(idle0), .outVld(outVld0), .outMsg(outMsg0), .doneVld(doneVld0), .bwdMsg(bwdMsg0),
    .appMsg(appMsg0), .chainOut(chainOut0)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int memA = PMAX;
  int memB = PMAX;
  int grp  = 0;

  function automatic int clampv(int x);
    return (x < -PMAX) ? -PMAX : x;
  endfunction
  function automatic int sat(int x);
    if (x > PMAX) return PMAX;
    if (x < -PMAX) return -PMAX;
    return x;
  endfunction
  function automatic int absv(int x);
    return (x < 0) ? -x : x;
  endfunction
  function automatic int bp(int a, int b);
    int m;
    m = (absv(a) < absv(b)) ? absv(a) : absv(b);
    return ((a < 0) ^ (b < 0)) ? -m : m;
  endfunction
  function automatic int sv(logic [W-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic chk(input string tag, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic runCheck(input int deg, input int vals[MAXD], input int par, input int bwdN,
                          input bit last, input int chain, input bit stall, input string ctx);
    int cv[MAXD];
    int lrExp[MAXD];
    int bn, pv, pq, all, ext, bwdE, fwdA, appA, fwdB, appB;
    if (grp == 0) begin
      memA = clampv(chain);
      memB = PMAX;
    end
    bn = last ? 0 : clampv(bwdN);
    pv = clampv(par);
    pq = sat(pv + bn);
    all = PMAX;
    for (int i = 0; i < deg; i++) begin
      cv[i] = clampv(vals[i]);
      all = bp(all, cv[i]);
    end
    for (int i = 0; i < deg; i++) begin
      ext = PMAX;
      for (int j = 0; j < deg; j++) if (j != i) ext = bp(ext, cv[j]);
      lrExp[i] = bp(bp(ext, pq), memA);
    end
    bwdE = bp(all, pq);
    fwdA = sat(bp(all, memA) + pv);
    appA = sat(fwdA + bn);
    fwdB = sat(bp(all, memB) + pv);
    appB = sat(fwdB + bn);

    @(negedge clk);
    chkStart = 1'b1; chkDeg = DEG_W'(deg); parLlr = W'(par); bwdNext = W'(bwdN);
    lastCheck = last; chainIn = W'(chain);
    @(negedge clk);
    chkStart = 1'b0; parLlr = W'($urandom); bwdNext = W'($urandom);
    lastCheck = 1'($urandom); chainIn = W'($urandom); chkDeg = DEG_W'($urandom);
    for (int i = 0; i < deg; i++) begin
      if (stall) begin
        inVld = 1'b0; inMsg = W'($urandom); chkStart = 1'b1; chkDeg = DEG_W'($urandom);
        @(negedge clk);
        chkStart = 1'b0;
      end
      inVld = 1'b1; inMsg = W'(vals[i]);
      @(negedge clk);
    end
    inVld = 1'b0; inMsg = W'($urandom);
    for (int e = 0; e < deg; e++) begin
      chk("R8 outVld", ctx, int'(outVld), 1);
      chk((deg == 1) ? "R11 outMsg" : "R2 outMsg", ctx, sv(outMsg), lrExp[e]);
      @(negedge clk);
    end
    chk("R8 outVld end", ctx, int'(outVld), 0);
    chk("R8 doneVld", ctx, int'(doneVld), 1);
    chk("R3 bwdMsg", ctx, sv(bwdMsg), bwdE);
    chk("R4 appMsg", ctx, sv(appMsg), appA);
    chk("R6 first-unit appMsg", ctx, sv(appMsg0), appB);
    @(negedge clk);
    chk("R8 idle", ctx, int'(idle), 1);
    chk("R5 chainOut", ctx, sv(chainOut), fwdA);
    chk("R6 first-unit chainOut", ctx, sv(chainOut0), fwdB);
    memA = fwdA;
    memB = fwdB;
    grp  = (grp + 1) % Q;
  endtask

  function automatic int rndv();
    return int'($signed(W'($urandom)));
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v[MAXD];
    rstN = 1'b0; chkStart = 1'b0; chkDeg = '0; lastCheck = 1'b0; inVld = 1'b0;
    parLlr = '0; bwdNext = '0; inMsg = '0; chainIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle", "reset", int'(idle), 1);
    chk("R1 outVld", "reset", int'(outVld), 0);
    chk("R1 doneVld", "reset", int'(doneVld), 0);
    chk("R1 chainOut", "reset", sv(chainOut), PMAX);

    // R6 group reload from chainIn
    v = '{5, -7, 12, 0};
    runCheck(3, v, 4, -3, 1'b0, 9, 1'b0, "R6 reload");
    // R11 degree one
    v = '{-6, 0, 0, 0};
    runCheck(1, v, 2, 5, 1'b0, 0, 1'b0, "R11 deg1");
    // R9 saturation and most negative code
    v = '{-32, -32, 20, 3};
    runCheck(4, v, 31, 31, 1'b0, -32, 1'b0, "R9 saturate");
    // R7 last check of code
    v = '{8, -9, 4, 11};
    runCheck(4, v, -5, 17, 1'b1, 3, 1'b0, "R7 last");
    // R10 stalls and spurious starts; equal minima
    v = '{-4, 4, 4, 10};
    runCheck(4, v, 7, -2, 1'b0, -13, 1'b1, "R10 stall");

    // R2 sweep every code in first slot
    for (int c = -32; c < 32; c++) begin
      v = '{c, rndv(), 0, 0};
      runCheck(2, v, rndv(), rndv(), 1'b0, rndv(), 1'b0, "R2 sweep");
    end

    // R4 mixed run
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < MAXD; i++) v[i] = rndv();
      runCheck(1 + (k % MAXD), v, rndv(), rndv(), (k % 7) == 6, rndv(), (k % 5) == 0,
               "R4 mixed");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule